// File: doc/BRIEF.md
# Instruction Address Sequencer with Register-File Return Stack

This block holds the 10-bit fetch address of a small controller core and moves it once per accepted operation. It can step the address forward by the length of the current instruction, overwrite all or a chosen subset of its bits from a target value, enter a subroutine, or leave one. Return addresses are not kept inside the block. They are written into, and read back from, the upper words of the core's general register file through a dedicated write port and read port. A 2-bit depth counter selects which of those words is used.

Descending through the stack at the wrong end is treated as a program hang. Calling with the depth counter already at its highest value, or returning with it at zero, does not wrap. It clears the address and the depth counter and raises a one-cycle hang-reset pulse for the rest of the core. A synchronous all-clear input performs the same clearing without the pulse.

Operations arrive on a valid-qualified command input with no ready signal. The block never applies back-pressure. It consumes the command in every cycle where `op_valid` is high, and the result appears on `pc_out` after the next rising edge. The register-file ports are plain strobes. The read port expects `pop_data` to be valid in the same cycle as `pop_idx`, which means an asynchronous read.

Top module: `pcs_top`

## Requirements
- R1: After `rst_n` is released, `pc_out` is 0, `sp_out` is 0, and `hang_rst` is 0.
- R2: The step operation (`op_kind`=0) adds `op_len` to `pc_out` modulo 1024, so 3FFh plus 1 gives 000h.
- R3: The jump operation (`op_kind`=1) sets each bit of `pc_out` where `tgt_mask` is 1 to the matching bit of `tgt_addr`, and leaves every other bit unchanged.
- R4: The call operation (`op_kind`=2) with `sp_out` below 3 writes `pc_out`+1 to register index 15−`sp_out` through the push port. In the same edge it loads all of `tgt_addr` into `pc_out` and increments `sp_out`. Push and pop are never active together.
- R5: The return operation (`op_kind`=3) with `sp_out` above 0 reads register index 16−`sp_out` through the pop port. It loads the value read plus 2, modulo 1024, into `pc_out` and decrements `sp_out`.
- R6: A call while `sp_out` is 3 writes nothing. On the next edge `pc_out` and `sp_out` become 0 and `hang_rst` goes high for exactly one cycle.
- R7: A return while `sp_out` is 0 reads nothing. On the next edge `pc_out` and `sp_out` become 0 and `hang_rst` goes high for exactly one cycle.
- R8: When `all_clr` is high, the next edge clears `pc_out` and `sp_out` regardless of the command. No push takes place and `hang_rst` stays 0.
- R9: While `op_valid` and `all_clr` are both low, `pc_out` and `sp_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| all_clr | input | 1 | Synchronous clear of address and depth |
| op_valid | input | 1 | Command present this cycle |
| op_kind | input | 2 | 0 step, 1 jump, 2 call, 3 return |
| op_len | input | 2 | Step size in words |
| tgt_mask | input | 10 | Bits loaded by a jump |
| tgt_addr | input | 10 | Jump or call target |
| pc_out | output | 10 | Current fetch address |
| sp_out | output | 2 | Stack depth counter |
| hang_rst | output | 1 | One-cycle hang-reset pulse |
| push_en | output | 1 | Register-file write strobe |
| push_idx | output | 4 | Register written |
| push_data | output | 10 | Return address written |
| pop_en | output | 1 | Register-file read strobe |
| pop_idx | output | 4 | Register read |
| pop_data | input | 10 | Word read, valid in the same cycle |

## Verification
Two functions can land in one cycle, and the bench provokes each pairing. A call issued at full depth combines a subroutine entry with the overflow reset. The check confirms that the clear wins: the address and depth go to zero, the pulse is raised, and the stack word at index Ch keeps its sentinel value. An all-clear issued together with a call combines the clear with a push. The check confirms that the address and depth go to zero with no pulse, and that the top stack word still holds its earlier content.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int PC_W = 10;
  localparam int SP_W = 2;
  localparam int RF_AW = 4;
  localparam int LEN_W = 2;

  typedef enum logic [1:0] {
    OP_STEP = 2'd0,
    OP_JUMP = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } op_e;
endpackage

// File: rtl/pcs_stack_ctl.sv
module pcs_stack_ctl
  import pcs_pkg::*;
#(
  parameter int SPW = SP_W,
  parameter int AW  = RF_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           want_call,
  input  logic           want_ret,
  output logic [SPW-1:0] sp,
  output logic           fault,
  output logic           do_push,
  output logic           do_pop,
  output logic [AW-1:0]  push_idx,
  output logic [AW-1:0]  pop_idx
);
  localparam logic [SPW-1:0] SP_MAX = '1;
  localparam logic [AW-1:0]  RF_TOP = '1;

  logic ovf, unf;

  assign ovf      = want_call && (sp == SP_MAX);
  assign unf      = want_ret  && (sp == '0);
  assign fault    = ovf || unf;
  assign do_push  = want_call && !ovf;
  assign do_pop   = want_ret  && !unf;
  assign push_idx = RF_TOP - AW'(sp);
  assign pop_idx  = RF_TOP - AW'(sp) + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sp <= '0;
    else if (clr)        sp <= '0;
    else if (fault)      sp <= '0;
    else if (do_push)    sp <= sp + SPW'(1);
    else if (do_pop)     sp <= sp - SPW'(1);
  end
endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
  import pcs_pkg::*;
#(
  parameter int W  = PC_W,
  parameter int LW = LEN_W
) (
  input  logic [W-1:0]  pc,
  input  op_e           kind,
  input  logic [LW-1:0] len,
  input  logic [W-1:0]  mask,
  input  logic [W-1:0]  addr,
  input  logic [W-1:0]  popped,
  output logic [W-1:0]  nxt,
  output logic [W-1:0]  ret_addr
);
  localparam logic [W-1:0] RET_ADJ = W'(2);

  assign ret_addr = pc + W'(1);

  always_comb begin
    unique case (kind)
      OP_STEP: nxt = pc + W'(len);
      OP_JUMP: nxt = (pc & ~mask) | (addr & mask);
      OP_CALL: nxt = addr;
      OP_RET:  nxt = popped + RET_ADJ;
      default: nxt = pc;
    endcase
  end
endmodule

// File: rtl/pcs_top.sv
module pcs_top
  import pcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             all_clr,
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic [LEN_W-1:0] op_len,
  input  logic [PC_W-1:0]  tgt_mask,
  input  logic [PC_W-1:0]  tgt_addr,
  output logic [PC_W-1:0]  pc_out,
  output logic [SP_W-1:0]  sp_out,
  output logic             hang_rst,
  output logic             push_en,
  output logic [RF_AW-1:0] push_idx,
  output logic [PC_W-1:0]  push_data,
  output logic             pop_en,
  output logic [RF_AW-1:0] pop_idx,
  input  logic [PC_W-1:0]  pop_data
);
  op_e            kind;
  logic           want_call, want_ret, fault;
  logic [PC_W-1:0] nxt_pc;

  assign kind      = op_e'(op_kind);
  assign want_call = op_valid && !all_clr && (kind == OP_CALL);
  assign want_ret  = op_valid && !all_clr && (kind == OP_RET);

  pcs_stack_ctl #(.SPW(SP_W), .AW(RF_AW)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (all_clr),
    .want_call(want_call),
    .want_ret (want_ret),
    .sp       (sp_out),
    .fault    (fault),
    .do_push  (push_en),
    .do_pop   (pop_en),
    .push_idx (push_idx),
    .pop_idx  (pop_idx)
  );

  pcs_next_pc #(.W(PC_W), .LW(LEN_W)) u_next (
    .pc      (pc_out),
    .kind    (kind),
    .len     (op_len),
    .mask    (tgt_mask),
    .addr    (tgt_addr),
    .popped  (pop_data),
    .nxt     (nxt_pc),
    .ret_addr(push_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out   <= '0;
      hang_rst <= 1'b0;
    end else begin
      hang_rst <= fault;
      if (all_clr || fault) pc_out <= '0;
      else if (op_valid)    pc_out <= nxt_pc;
    end
  end
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk
  import pcs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             all_clr,
  input logic             op_valid,
  input logic [PC_W-1:0]  pc_out,
  input logic [SP_W-1:0]  sp_out,
  input logic             hang_rst,
  input logic             push_en,
  input logic             pop_en,
  input logic [PC_W-1:0]  pop_data
);
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_en && pop_en)); // R4
  AST_CALL_DEEPENS: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> sp_out == $past(sp_out) + 2'd1); // R4
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> pc_out == 10'($past(pop_data) + 10'd2)); // R5
  AST_HANG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hang_rst |=> !hang_rst); // R6
  AST_HANG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hang_rst |-> (pc_out == '0 && sp_out == '0)); // R7
  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    all_clr |=> (!hang_rst && pc_out == '0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !all_clr) |=> ($stable(pc_out) && $stable(sp_out))); // R9
endmodule

bind pcs_top pcs_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .all_clr (all_clr),
  .op_valid(op_valid),
  .pc_out  (pc_out),
  .sp_out  (sp_out),
  .hang_rst(hang_rst),
  .push_en (push_en),
  .pop_en  (pop_en),
  .pop_data(pop_data)
);

// File: tb/pcs_top_tb.sv
module pcs_top_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       all_clr = 0;
  logic       op_valid = 0;
  logic [1:0] op_kind = 0;
  logic [1:0] op_len = 0;
  logic [9:0] tgt_mask = 0;
  logic [9:0] tgt_addr = 0;
  logic [9:0] pc_out;
  logic [1:0] sp_out;
  logic       hang_rst;
  logic       push_en, pop_en;
  logic [3:0] push_idx, pop_idx;
  logic [9:0] push_data, pop_data;

  logic [9:0] rf [16];
  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign pop_data = rf[pop_idx];
  always @(posedge clk) if (push_en) rf[push_idx] <= push_data;

  pcs_top u_dut (
    .clk(clk), .rst_n(rst_n), .all_clr(all_clr), .op_valid(op_valid),
    .op_kind(op_kind), .op_len(op_len), .tgt_mask(tgt_mask), .tgt_addr(tgt_addr),
    .pc_out(pc_out), .sp_out(sp_out), .hang_rst(hang_rst),
    .push_en(push_en), .push_idx(push_idx), .push_data(push_data),
    .pop_en(pop_en), .pop_idx(pop_idx), .pop_data(pop_data)
  );

  // kind, len, mask, addr, expected pc, expected sp
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 2'd1, 10'h000, 10'h000, 10'h001, 2'd0}, // R2
    {2'd0, 2'd2, 10'h000, 10'h000, 10'h003, 2'd0}, // R2
    {2'd1, 2'd0, 10'h3FF, 10'h100, 10'h100, 2'd0}, // R3
    {2'd1, 2'd0, 10'h00F, 10'h005, 10'h105, 2'd0}, // R3
    {2'd2, 2'd0, 10'h000, 10'h200, 10'h200, 2'd1}, // R4
    {2'd0, 2'd1, 10'h000, 10'h000, 10'h201, 2'd1}, // R2
    {2'd2, 2'd0, 10'h000, 10'h300, 10'h300, 2'd2}, // R4
    {2'd2, 2'd0, 10'h000, 10'h050, 10'h050, 2'd3}, // R4
    {2'd3, 2'd0, 10'h000, 10'h000, 10'h303, 2'd2}, // R5
    {2'd3, 2'd0, 10'h000, 10'h000, 10'h204, 2'd1}, // R5
    {2'd3, 2'd0, 10'h000, 10'h000, 10'h108, 2'd0}, // R5
    {2'd1, 2'd0, 10'h300, 10'h3FF, 10'h308, 2'd0}  // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [1:0] l,
                       input logic [9:0] m, input logic [9:0] a, input logic clr);
    @(negedge clk);
    op_valid = 1; op_kind = k; op_len = l; tgt_mask = m; tgt_addr = a; all_clr = clr;
    @(negedge clk);
    op_valid = 0; all_clr = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 10'h155;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 pc", pc_out, 0);
    check("R1 sp", sp_out, 0);
    check("R1 hang", hang_rst, 0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][35:34], VEC[i][33:32], VEC[i][31:22], VEC[i][21:12], 1'b0);
      check($sformatf("vec%0d pc R2/R3/R4/R5", i), pc_out, VEC[i][11:2]);
      check($sformatf("vec%0d sp R4/R5", i), sp_out, VEC[i][1:0]);
    end
    check("R4 slot F", rf[15], 10'h106);
    check("R4 slot E", rf[14], 10'h202);
    check("R4 slot D", rf[13], 10'h301);

    // R7 underflow: return at depth 0
    issue(2'd3, 2'd0, 10'h000, 10'h000, 1'b0);
    check("R7 pc", pc_out, 0);
    check("R7 sp", sp_out, 0);
    check("R7 hang", hang_rst, 1);
    @(negedge clk);
    check("R7 pulse end", hang_rst, 0);

    // R9 idle hold
    issue(2'd1, 2'd0, 10'h3FF, 10'h2A5, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 pc", pc_out, 10'h2A5);
    check("R9 sp", sp_out, 0);

    // R6 overflow: call at depth 3
    issue(2'd2, 2'd0, 10'h000, 10'h010, 1'b0);
    issue(2'd2, 2'd0, 10'h000, 10'h020, 1'b0);
    issue(2'd2, 2'd0, 10'h000, 10'h030, 1'b0);
    check("R6 depth3", sp_out, 3);
    issue(2'd2, 2'd0, 10'h000, 10'h040, 1'b0);
    check("R6 pc", pc_out, 0);
    check("R6 sp", sp_out, 0);
    check("R6 hang", hang_rst, 1);
    check("R6 no write C", rf[12], 10'h155);
    @(negedge clk);
    check("R6 pulse end", hang_rst, 0);

    // R8 all-clear together with a call
    issue(2'd1, 2'd0, 10'h3FF, 10'h123, 1'b0);
    issue(2'd2, 2'd0, 10'h000, 10'h200, 1'b1);
    check("R8 pc", pc_out, 0);
    check("R8 sp", sp_out, 0);
    check("R8 hang", hang_rst, 0);
    check("R8 no push", rf[15], 10'h2A6);

    // R2 wrap
    issue(2'd1, 2'd0, 10'h3FF, 10'h3FF, 1'b0);
    issue(2'd0, 2'd1, 10'h000, 10'h000, 1'b0);
    check("R2 wrap", pc_out, 10'h000);
    issue(2'd0, 2'd3, 10'h000, 10'h000, 1'b0);
    check("R2 len3", pc_out, 10'h003);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule